// File: doc/BRIEF.md
# Two-Tier Prioritized Vectored Interrupt Controller

This block gathers a wide bank of peripheral interrupt request lines and reduces them to one 3-bit encoded request level for a processor core. Level 7 is the most urgent, level 1 the least urgent, and 0 means that nothing is pending. Arbitration has two tiers. Every source carries a level. Inside a level, a priority field ranks the sources. When two sources have the same level and the same priority, the lower source number wins.

Most sources are programmable. Software writes each one's level and priority through a small write port. The remaining sources are hard-wired, one at each level from 1 to 7. Sources can be masked one at a time, and one global bit masks all of them together.

The core acknowledges a request by strobing the level it is servicing. One cycle later the block returns an 8-bit vector for the winning source at that level. Software can instead read a registered vector for the overall winner. A wake output tells power control that an unmasked request is pending.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq_level` is 0, `wake` is 0, `ack_vld` is 0, `sw_vec` holds the spurious vector 24, every source is masked and the global mask is clear.
- R2: A write to address i (0 to 49) sets the control field of programmable source i. Bits [5:3] hold the level and bits [2:0] hold the within-level priority. A source whose level is 0 never takes part in arbitration. Control fields reset to 0.
- R3: Source 50+j (j from 0 to 6) has fixed level j+1 and within-level priority 4. Writes to addresses 50 to 56 do not change them.
- R4: `irq_level` is registered. It shows the highest level among eligible sources one clock edge after the inputs that produce it. A source is eligible when it is requesting, unmasked, the global mask is clear and its level is not 0.
- R5: Among eligible sources of the same level, the higher priority field wins. If the priority fields are also equal, the lower source index wins.
- R6: A write to address 64+i with data bit 0 set masks source i. The same write with bit 0 clear unmasks it. A masked source does not take part in arbitration.
- R7: A write to address 127 sets the global mask from data bit 0. While the global mask is set, `irq_level` is 0 and `wake` is 0.
- R8: When `ack_stb` is high at a clock edge, `ack_vld` is high after that edge. `ack_vec` then holds 64 plus the index of the winning eligible source at level `ack_lvl`. `ack_vld` is low after any edge at which `ack_stb` is low.
- R9: If no eligible source exists at the acknowledged level, `ack_vec` returns the spurious vector 24.
- R10: `sw_vec` is registered every cycle with 64 plus the index of the overall winner, or with 24 when nothing is eligible.
- R11: `wake` is registered. It is high exactly when at least one source was eligible at the previous edge.
- R12: Requests are level-sensitive. When a source drops its request, it stops counting at the next edge, and the next-best source takes over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 57 | Request line per source, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register write address |
| cfg_wdata | input | 6 | Register write data |
| ack_stb | input | 1 | Hardware acknowledge strobe |
| ack_lvl | input | 3 | Level being acknowledged |
| irq_level | output | 3 | Encoded request level to the core |
| wake | output | 1 | Unmasked request pending |
| ack_vld | output | 1 | Acknowledge vector valid |
| ack_vec | output | 8 | Acknowledge vector |
| sw_vec | output | 8 | Vector of the current overall winner |

## Verification
The test looks for faults in the stored state and shows where each one appears at the ports. A corrupted control field or mask bit changes `irq_level` and `sw_vec` one edge after the write that should have taken effect, because both outputs are rebuilt from that state every cycle. A fault in the tie-break or in the level filter used for acknowledges shows up only on the vector, one cycle after the strobe. The test therefore sets up ties and empty levels on purpose and acknowledges each of them.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_PROG       = 50,
  parameter int N_FIXED      = 7,
  parameter int LVL_W        = 3,
  parameter int PRI_W        = 3,
  parameter int ADDR_W       = 7,
  parameter int VEC_BASE     = 64,
  parameter int VEC_SPUR     = 24,
  parameter int FIX_PRI      = 4,
  parameter int MASK_BASE    = 64,
  parameter int MASKALL_ADDR = 127
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_PROG+N_FIXED-1:0]  irq_req,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [LVL_W+PRI_W-1:0]     cfg_wdata,
  input  logic                       ack_stb,
  input  logic [LVL_W-1:0]           ack_lvl,
  output logic [LVL_W-1:0]           irq_level,
  output logic                       wake,
  output logic                       ack_vld,
  output logic [7:0]                 ack_vec,
  output logic [7:0]                 sw_vec
);
  localparam int NSRC  = N_PROG + N_FIXED;
  localparam int KEY_W = LVL_W + PRI_W;
  localparam int IDX_W = $clog2(NSRC);
  localparam logic [7:0] VB = 8'(VEC_BASE);
  localparam logic [7:0] VS = 8'(VEC_SPUR);

  logic [KEY_W-1:0] ctrl [N_PROG];
  logic [KEY_W-1:0] key  [NSRC];
  logic [NSRC-1:0]  mask;
  logic             mask_all;
  logic [NSRC-1:0]  elig;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      if (g < N_PROG) begin : g_prog
        assign key[g] = ctrl[g];
      end else begin : g_fix
        assign key[g] = {LVL_W'(g - N_PROG + 1), PRI_W'(FIX_PRI)};
      end
      assign elig[g] = irq_req[g] & ~mask[g] & ~mask_all &
                       (key[g][KEY_W-1 -: LVL_W] != '0);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_PROG; i++) ctrl[i] <= '0;
      mask     <= '1;
      mask_all <= 1'b0;
    end else if (cfg_we) begin
      for (int i = 0; i < N_PROG; i++)
        if (cfg_addr == ADDR_W'(i)) ctrl[i] <= cfg_wdata;
      for (int i = 0; i < NSRC; i++)
        if (cfg_addr == ADDR_W'(MASK_BASE + i)) mask[i] <= cfg_wdata[0];
      if (cfg_addr == ADDR_W'(MASKALL_ADDR)) mask_all <= cfg_wdata[0];
    end
  end

  logic [KEY_W-1:0] best_key, a_key;
  logic [IDX_W-1:0] best_idx, a_idx;
  logic             found, a_found;

  always_comb begin
    best_key = '0; best_idx = '0; found = 1'b0;
    a_key    = '0; a_idx    = '0; a_found = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!found || key[i] > best_key)) begin
        best_key = key[i];
        best_idx = IDX_W'(i);
        found    = 1'b1;
      end
      if (elig[i] && key[i][KEY_W-1 -: LVL_W] == ack_lvl &&
          (!a_found || key[i] > a_key)) begin
        a_key   = key[i];
        a_idx   = IDX_W'(i);
        a_found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_level <= '0;
      wake      <= 1'b0;
      sw_vec    <= VS;
      ack_vld   <= 1'b0;
      ack_vec   <= '0;
    end else begin
      irq_level <= found ? best_key[KEY_W-1 -: LVL_W] : '0;
      wake      <= found;
      sw_vec    <= found ? VB + 8'(best_idx) : VS;
      ack_vld   <= ack_stb;
      if (ack_stb) ack_vec <= a_found ? VB + 8'(a_idx) : VS;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int NSRC     = 57,
  parameter int LVL_W    = 3,
  parameter int VEC_BASE = 64,
  parameter int VEC_SPUR = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_stb,
  input logic             mask_all,
  input logic [LVL_W-1:0] irq_level,
  input logic             wake,
  input logic             ack_vld,
  input logic [7:0]       ack_vec,
  input logic [7:0]       sw_vec
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (irq_level == '0 && !wake && !ack_vld));

  assert_wake_tracks_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wake == (irq_level != '0));

  assert_mask_all_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_all |=> (irq_level == '0 && !wake));

  assert_ack_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |=> ack_vld);

  assert_ack_valid_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_stb |=> !ack_vld);

  assert_ack_vec_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> (ack_vec == 8'(VEC_SPUR) ||
                 (ack_vec >= 8'(VEC_BASE) && ack_vec < 8'(VEC_BASE + NSRC))));

  assert_sw_vec_spur_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == '0) |-> sw_vec == 8'(VEC_SPUR));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .NSRC(NSRC), .LVL_W(LVL_W), .VEC_BASE(VEC_BASE), .VEC_SPUR(VEC_SPUR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_stb(ack_stb), .mask_all(mask_all),
  .irq_level(irq_level), .wake(wake), .ack_vld(ack_vld),
  .ack_vec(ack_vec), .sw_vec(sw_vec)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  localparam int NSRC = 57;

  logic            clk = 0;
  logic            rst_n = 0;
  logic [NSRC-1:0] irq_req = '0;
  logic            cfg_we = 0;
  logic [6:0]      cfg_addr = '0;
  logic [5:0]      cfg_wdata = '0;
  logic            ack_stb = 0;
  logic [2:0]      ack_lvl = '0;
  logic [2:0]      irq_level;
  logic            wake, ack_vld;
  logic [7:0]      ack_vec, sw_vec;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ack_stb(ack_stb),
    .ack_lvl(ack_lvl), .irq_level(irq_level), .wake(wake),
    .ack_vld(ack_vld), .ack_vec(ack_vec), .sw_vec(sw_vec)
  );

  always #10 clk = ~clk;

  typedef struct {
    int         kind;
    logic [2:0] lvl;
    logic       wk;
    logic [7:0] vec;
    string      req;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  int mlvl [NSRC];
  int mpri [NSRC];
  bit mmask [NSRC];
  bit mall;

  function automatic int winner(int lvl_sel);
    int best = -1;
    for (int i = 0; i < NSRC; i++) begin
      if (irq_req[i] && !mmask[i] && !mall && mlvl[i] != 0 &&
          (lvl_sel < 0 || mlvl[i] == lvl_sel)) begin
        if (best < 0 || mlvl[i] > mlvl[best] ||
            (mlvl[i] == mlvl[best] && mpri[i] > mpri[best]))
          best = i;
      end
    end
    return best;
  endfunction

  always begin
    exp_t e;
    wait (q.size() > 0);
    e = q.pop_front();
    checks++;
    if (e.kind == 0) begin
      if (irq_level !== e.lvl || wake !== e.wk || sw_vec !== e.vec) begin
        fails++;
        $display("FAIL %s: level/wake/sw_vec = %0d/%0d/%0d expected %0d/%0d/%0d",
                 e.req, irq_level, wake, sw_vec, e.lvl, e.wk, e.vec);
      end
    end else if (e.kind == 1) begin
      if (ack_vld !== 1'b1 || ack_vec !== e.vec) begin
        fails++;
        $display("FAIL %s: ack_vld/ack_vec = %0d/%0d expected 1/%0d",
                 e.req, ack_vld, ack_vec, e.vec);
      end
    end else begin
      if (ack_vld !== 1'b0) begin
        fails++;
        $display("FAIL %s: ack_vld = %0d expected 0", e.req, ack_vld);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_state(string req);
    exp_t e;
    int w = winner(-1);
    e.kind = 0;
    e.lvl  = (w < 0) ? 3'd0 : 3'(mlvl[w]);
    e.wk   = (w >= 0);
    e.vec  = (w < 0) ? 8'd24 : 8'(64 + w);
    e.req  = req;
    q.push_back(e);
    #1;
  endtask

  task automatic wr(int addr, int data);
    cfg_we = 1; cfg_addr = 7'(addr); cfg_wdata = 6'(data);
    step();
    cfg_we = 0;
    if (addr < 50) begin
      mlvl[addr] = (data >> 3) & 7;
      mpri[addr] = data & 7;
    end else if (addr >= 64 && addr < 64 + NSRC) begin
      mmask[addr - 64] = data[0];
    end else if (addr == 127) begin
      mall = data[0];
    end
    step();
  endtask

  task automatic set_req(int idx, bit v);
    irq_req[idx] = v;
    step();
  endtask

  task automatic ack(int lvl, string req);
    exp_t e;
    int w;
    ack_lvl = 3'(lvl);
    ack_stb = 1;
    w = winner(lvl);
    step();
    ack_stb = 0;
    e.kind = 1; e.lvl = '0; e.wk = 0; e.req = req;
    e.vec = (w < 0) ? 8'd24 : 8'(64 + w);
    q.push_back(e);
    #1;
    step();
    e.kind = 2;
    q.push_back(e);
    #1;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    if (!done) $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NSRC; i++) begin
      mlvl[i] = (i >= 50) ? i - 49 : 0;
      mpri[i] = (i >= 50) ? 4 : 0;
      mmask[i] = 1;
    end
    mall = 0;
    repeat (3) @(negedge clk);
    expect_state("R1 reset outputs");
    q.push_back('{2, 3'd0, 1'b0, 8'd0, "R1 ack_vld idle"}); #1;
    rst_n = 1;
    step();

    set_req(50, 1);
    expect_state("R6 masked source ignored");
    set_req(3, 1);
    wr(64 + 3, 0);
    expect_state("R2 level zero source ignored");
    wr(64 + 50, 0);
    expect_state("R3 fixed source 50 at level 1");

    wr(3, (5 << 3) | 2);
    expect_state("R2 R4 programmed level 5");
    wr(64 + 10, 0); wr(10, (5 << 3) | 6); set_req(10, 1);
    expect_state("R5 higher priority wins");
    wr(64 + 7, 0); wr(7, (5 << 3) | 6); set_req(7, 1);
    expect_state("R5 tie goes to lower index");

    wr(64 + 56, 0); set_req(56, 1);
    expect_state("R3 fixed source 56 level 7");
    cfg_we = 1; cfg_addr = 7'd56; cfg_wdata = 6'd0; step(); cfg_we = 0; step();
    expect_state("R3 write to fixed address ignored");

    ack(5, "R8 ack level 5 vector");
    ack(1, "R8 ack level 1 vector");
    ack(7, "R8 ack level 7 vector");
    ack(3, "R9 empty level spurious");

    wr(127, 1);
    expect_state("R7 mask-all blocks");
    ack(5, "R9 mask-all ack spurious");
    wr(127, 0);
    expect_state("R7 mask-all released");

    set_req(56, 0);
    expect_state("R12 dropped request falls back");
    wr(64 + 7, 1);
    expect_state("R6 masking tie winner");
    irq_req[50] = 0;
    step();
    expect_state("R4 one-edge update");
    set_req(3, 0); set_req(10, 0); set_req(7, 0);
    expect_state("R10 R11 idle returns spurious no wake");

    step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule